// File: doc/BRIEF.md
# Ring Occupancy Near-Full Classifier

This block watches how many valid entries sit in a consumer ring and sorts that count into one of three occupancy levels: safe, near-full or critical. Two thresholds set the level boundaries, and both can be changed at run time. The block also holds a sticky near-full flag. An external near-full event pulse sets the flag. While the flag is set and occupancy stays high, the block reports near-full pressure and doubles the number of entries the consumer may service in one pass. When occupancy falls below the safe threshold, the flag clears and the service limit returns to its base value.

The consumer raises a one-cycle evaluate strobe before each service pass. The block samples the count, the thresholds and the base limit on that edge and presents the level, the near-full indication and the effective limit one cycle later. The outputs then hold until the next strobe. The strobe and the event pulse are plain control pins. There is no ready signal and no back-pressure: every strobe is taken, and the consumer may strobe on every cycle. Interrupt generation and ring pointer handling belong elsewhere.

Top module: `ring_nf_classifier`

## Requirements
- R1: Level codes are safe = 0, near-full = 1 and critical = 2. `level_o`, `near_full_o` and `reap_limit_o` update on the clock edge after a cycle with `eval_i` high and hold their values in every other cycle. `level_o` always shows the classification from the last evaluation.
- R2: The level is critical when the valid count is strictly greater than the critical threshold.
- R3: When the level is not critical, it is safe if the valid count is strictly less than the safe threshold. Otherwise it is near-full, and this includes a count equal to either threshold.
- R4: When an evaluation sees the flag clear, `near_full_o` is 0 and `reap_limit_o` equals the base limit, whatever the level.
- R5: When an evaluation sees the flag set and the level is near-full or critical, `near_full_o` is 1 and `reap_limit_o` is twice the base limit. The flag stays set.
- R6: When an evaluation sees the flag set and the level is safe, the flag clears, `near_full_o` is 0 and `reap_limit_o` equals the base limit. Later evaluations behave as with the flag clear until a new event arrives.
- R7: A high `nf_event_i` sets the flag. If the event and a safe-level clear happen in the same cycle, the flag stays set.
- R8: The doubled limit saturates at 2^LIM_W-1 and does not wrap. For example, with LIM_W = 8 a base of 128 gives 255 and a base of 127 gives 254.
- R9: Reset sets all outputs to 0 and clears the flag.
- R10: An evaluation uses the flag value held before its clock edge. An event in the same cycle as a strobe first affects the next evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate strobe, one cycle per service pass |
| nf_event_i | input | 1 | Near-full event pulse; sets the sticky flag |
| valid_cnt_i | input | CNT_W | Valid-entry count of the ring |
| safe_thr_i | input | CNT_W | Safe threshold |
| crit_thr_i | input | CNT_W | Critical threshold |
| base_limit_i | input | LIM_W | Base per-pass reap limit |
| level_o | output | 2 | Level code from the last evaluation |
| near_full_o | output | 1 | Near-full pressure indication |
| reap_limit_o | output | LIM_W | Effective per-pass reap limit |

## Verification
The hardest case to reach from the ports is a near-full event that lands in the same cycle as an evaluation. That evaluation sees the flag as set and the level as safe, so it would clear the flag. The bench sets the flag with an earlier pulse, then raises the event together with a safe-level strobe. A following strobe at a near-full level must then report pressure. The bench also raises the event alongside a strobe while the flag is clear, which shows that the flag takes effect only on the next pass, and it drives counts that sit exactly on each threshold.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    LVL_SAFE = 2'd0,
    LVL_NEAR = 2'd1,
    LVL_CRIT = 2'd2
  } nfc_level_e;
endpackage

// File: rtl/nfc_level_classify.sv
module nfc_level_classify
  import nfc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] safe_thr_i,
  input  logic [CNT_W-1:0] crit_thr_i,
  output nfc_level_e       level_o
);
  // Critical takes priority; safe only when strictly under the lower bound.
  always_comb begin
    if (count_i > crit_thr_i)      level_o = LVL_CRIT;
    else if (count_i < safe_thr_i) level_o = LVL_SAFE;
    else                           level_o = LVL_NEAR;
  end
endmodule

// File: rtl/nfc_limit_scale.sv
module nfc_limit_scale #(
  parameter int LIM_W = 8
) (
  input  logic [LIM_W-1:0] base_i,
  input  logic             boost_i,
  output logic [LIM_W-1:0] limit_o
);
  localparam logic [LIM_W-1:0] LIM_MAX = {LIM_W{1'b1}};

  logic [LIM_W-1:0] doubled;

  // Saturate when the top bit would shift out.
  always_comb begin
    if (base_i[LIM_W-1]) doubled = LIM_MAX;
    else                 doubled = {base_i[LIM_W-2:0], 1'b0};
    limit_o = boost_i ? doubled : base_i;
  end
endmodule

// File: rtl/ring_nf_classifier.sv
module ring_nf_classifier
  import nfc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic             nf_event_i,
  input  logic [CNT_W-1:0] valid_cnt_i,
  input  logic [CNT_W-1:0] safe_thr_i,
  input  logic [CNT_W-1:0] crit_thr_i,
  input  logic [LIM_W-1:0] base_limit_i,
  output logic [1:0]       level_o,
  output logic             near_full_o,
  output logic [LIM_W-1:0] reap_limit_o
);
  nfc_level_e       lvl_w;
  logic             flag_q;
  logic             pressure_w;
  logic             clear_w;
  logic [LIM_W-1:0] limit_w;

  nfc_level_classify #(.CNT_W(CNT_W)) u_classify (
    .count_i    (valid_cnt_i),
    .safe_thr_i (safe_thr_i),
    .crit_thr_i (crit_thr_i),
    .level_o    (lvl_w)
  );

  assign pressure_w = flag_q && (lvl_w != LVL_SAFE);
  assign clear_w    = eval_i && flag_q && (lvl_w == LVL_SAFE);

  nfc_limit_scale #(.LIM_W(LIM_W)) u_scale (
    .base_i  (base_limit_i),
    .boost_i (pressure_w),
    .limit_o (limit_w)
  );

  // Sticky flag: an event set beats a safe-level clear.
  always_ff @(posedge clk) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (nf_event_i) flag_q <= 1'b1;
    else if (clear_w)    flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_o      <= LVL_SAFE;
      near_full_o  <= 1'b0;
      reap_limit_o <= '0;
    end else if (eval_i) begin
      level_o      <= lvl_w;
      near_full_o  <= pressure_w;
      reap_limit_o <= limit_w;
    end
  end
endmodule

// File: rtl/ring_nf_classifier_chk.sv
module ring_nf_classifier_chk #(
  parameter int CNT_W = 10,
  parameter int LIM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_i,
  input logic             nf_event_i,
  input logic [CNT_W-1:0] valid_cnt_i,
  input logic [CNT_W-1:0] safe_thr_i,
  input logic [CNT_W-1:0] crit_thr_i,
  input logic [LIM_W-1:0] base_limit_i,
  input logic [1:0]       level_o,
  input logic             near_full_o,
  input logic [LIM_W-1:0] reap_limit_o,
  input logic             flag_q
);
  p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'd3);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> ($stable(level_o) && $stable(near_full_o) && $stable(reap_limit_o)));

  p_crit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && valid_cnt_i > crit_thr_i) |=> level_o == 2'd2);

  p_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && valid_cnt_i <= crit_thr_i && valid_cnt_i < safe_thr_i) |=> level_o == 2'd0);

  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !flag_q) |=> (!near_full_o && reap_limit_o == $past(base_limit_i)));

  p_nf_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    near_full_o |-> level_o != 2'd0);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && flag_q && !nf_event_i && valid_cnt_i <= crit_thr_i && valid_cnt_i < safe_thr_i)
    |=> !flag_q);

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nf_event_i |=> flag_q);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && flag_q) |=> reap_limit_o >= $past(base_limit_i));
endmodule

bind ring_nf_classifier ring_nf_classifier_chk #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eval_i       (eval_i),
  .nf_event_i   (nf_event_i),
  .valid_cnt_i  (valid_cnt_i),
  .safe_thr_i   (safe_thr_i),
  .crit_thr_i   (crit_thr_i),
  .base_limit_i (base_limit_i),
  .level_o      (level_o),
  .near_full_o  (near_full_o),
  .reap_limit_o (reap_limit_o),
  .flag_q       (flag_q)
);

// File: tb/ring_nf_classifier_bench.sv
`timescale 1ns/1ps
module ring_nf_classifier_bench;
  localparam int CNT_W = 10;
  localparam int LIM_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             eval_i = 1'b0;
  logic             nf_event_i = 1'b0;
  logic [CNT_W-1:0] valid_cnt_i = '0;
  logic [CNT_W-1:0] safe_thr_i = 10'd100;
  logic [CNT_W-1:0] crit_thr_i = 10'd200;
  logic [LIM_W-1:0] base_limit_i = 8'd16;
  logic [1:0]       level_o;
  logic             near_full_o;
  logic [LIM_W-1:0] reap_limit_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ring_nf_classifier #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_ring_nf_classifier (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .nf_event_i(nf_event_i),
    .valid_cnt_i(valid_cnt_i), .safe_thr_i(safe_thr_i), .crit_thr_i(crit_thr_i),
    .base_limit_i(base_limit_i), .level_o(level_o), .near_full_o(near_full_o),
    .reap_limit_o(reap_limit_o)
  );

  typedef struct packed {
    logic       pre_ev;
    logic [9:0] cnt;
    logic [7:0] base;
    logic [1:0] lvl;
    logic       nf;
    logic [7:0] lim;
  } vec_t;

  // Thresholds fixed at safe=100, crit=200; vectors run in order.
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 10'd50,  8'd16,  2'd0, 1'b0, 8'd16},   // R4 safe, flag clear
    '{1'b0, 10'd150, 8'd16,  2'd1, 1'b0, 8'd16},   // R4 near, flag clear
    '{1'b0, 10'd250, 8'd16,  2'd2, 1'b0, 8'd16},   // R2/R4
    '{1'b1, 10'd150, 8'd16,  2'd1, 1'b1, 8'd32},   // R5/R7
    '{1'b0, 10'd250, 8'd16,  2'd2, 1'b1, 8'd32},   // R5 critical
    '{1'b0, 10'd100, 8'd16,  2'd1, 1'b1, 8'd32},   // R3 equal safe
    '{1'b0, 10'd200, 8'd16,  2'd1, 1'b1, 8'd32},   // R3 equal crit
    '{1'b0, 10'd201, 8'd16,  2'd2, 1'b1, 8'd32},   // R2 just above
    '{1'b0, 10'd99,  8'd16,  2'd0, 1'b0, 8'd16},   // R6 clear
    '{1'b0, 10'd150, 8'd16,  2'd1, 1'b0, 8'd16},   // R6 stays clear
    '{1'b1, 10'd150, 8'd200, 2'd1, 1'b1, 8'd255},  // R8 saturate
    '{1'b0, 10'd150, 8'd127, 2'd1, 1'b1, 8'd254},  // R8 edge below
    '{1'b0, 10'd150, 8'd128, 2'd1, 1'b1, 8'd255},  // R8 edge at
    '{1'b0, 10'd10,  8'd5,   2'd0, 1'b0, 8'd5}     // R6 clear
  };

  task automatic check(input string req, input logic [1:0] el, input logic enf,
                       input logic [7:0] elim);
    checks++;
    if (level_o !== el || near_full_o !== enf || reap_limit_o !== elim) begin
      failures++;
      $display("FAIL %s: lvl=%0d nf=%0d lim=%0d expected lvl=%0d nf=%0d lim=%0d",
               req, level_o, near_full_o, reap_limit_o, el, enf, elim);
    end
  endtask

  task automatic pulse_event();
    @(negedge clk); nf_event_i = 1'b1;
    @(negedge clk); nf_event_i = 1'b0;
  endtask

  task automatic evaluate(input logic [9:0] cnt, input logic [7:0] base, input logic ev);
    @(negedge clk);
    valid_cnt_i = cnt; base_limit_i = base; eval_i = 1'b1; nf_event_i = ev;
    @(negedge clk);
    eval_i = 1'b0; nf_event_i = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: expired expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 2'd0, 1'b0, 8'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].pre_ev) pulse_event();
      evaluate(TBL[i].cnt, TBL[i].base, 1'b0);
      check($sformatf("R1 vec %0d", i), TBL[i].lvl, TBL[i].nf, TBL[i].lim);
    end

    // R1: outputs hold without a strobe
    @(negedge clk); valid_cnt_i = 10'd300; base_limit_i = 8'd77;
    repeat (3) @(negedge clk);
    check("R1 hold", 2'd0, 1'b0, 8'd5);

    // R10: event together with strobe, flag clear -> next pass only
    evaluate(10'd150, 8'd20, 1'b1);
    check("R10 same-cycle event", 2'd1, 1'b0, 8'd20);
    evaluate(10'd150, 8'd20, 1'b0);
    check("R10 next pass", 2'd1, 1'b1, 8'd40);

    // R7: event coincides with safe-level clear; set wins
    evaluate(10'd20, 8'd20, 1'b1);
    check("R7 coincide", 2'd0, 1'b0, 8'd20);
    evaluate(10'd150, 8'd20, 1'b0);
    check("R7 set wins", 2'd1, 1'b1, 8'd40);

    // R3 with moved thresholds
    @(negedge clk); safe_thr_i = 10'd30; crit_thr_i = 10'd40;
    evaluate(10'd35, 8'd3, 1'b0);
    check("R3 new window", 2'd1, 1'b1, 8'd6);
    evaluate(10'd41, 8'd3, 1'b0);
    check("R2 new window", 2'd2, 1'b1, 8'd6);

    // R9: reset mid-run clears outputs and flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid reset", 2'd0, 1'b0, 8'd0);
    rst_n = 1'b1;
    evaluate(10'd35, 8'd3, 1'b0);
    check("R9 flag cleared", 2'd1, 1'b0, 8'd3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule